// File: doc/BRIEF.md
# Dual Reloadable Down-Counting Timer

This block holds two independent down-counters behind a small register interface. Each counter decrements once per cycle of a shared tick-enable input, provided its own enable bit is set. On the tick where a counter stands at zero it expires. It then either reloads from its own reload register, for periodic operation, or stops at zero and clears its own enable bit, for one-shot operation. Software can write the live count of either counter directly and can read it back at any time.

Every expiry latches a bit in an interrupt cause register. Software clears a cause bit by writing zero to it. A separate mask register qualifies the cause bits, and the level interrupt output is high whenever a cause bit and its mask bit are both set. The count width, the number of counters and whether the interrupt output is registered are parameters. The register interface is a single write strobe with address and data. Reads are combinational from the address.

Top module: `dual_timer`

## Requirements
- R1: After reset the control, count, reload, cause and mask registers all read 0, and `irq` is low.
- R2: A counter keeps its value on any cycle where `tick_en` is low or its enable bit is clear.
- R3: On a cycle with `tick_en` high and its enable bit set, a non-zero counter decreases by exactly one.
- R4: On an enabled tick at count 0 with reload on, the counter loads its reload value. A reload value of N-1 therefore gives a period of N ticks, and a reload of 0xFFFFFFFF wraps a free-running counter back to 0xFFFFFFFF.
- R5: On an enabled tick at count 0 with reload off, the counter stays at 0 and its enable bit in the control register reads back as 0, so the counter does not count again.
- R6: A write to a count register sets that count on the next clock. This write takes priority over a tick in the same cycle.
- R7: Register map, in byte addresses. Control is at 0x00, with bit 0 for counter 0 enable, bit 1 for counter 0 reload, bit 2 for counter 1 enable and bit 3 for counter 1 reload. Counter 0 reload is at 0x10 and its count at 0x14. Counter 1 reload is at 0x18 and its count at 0x1C. Cause is at 0x40 and mask at 0x44. All of these registers read back what was written, or the live count.
- R8: An expiry of counter 0 sets cause bit 0, and an expiry of counter 1 sets cause bit 1. A cause write clears the bits written as 0 and leaves the bits written as 1 unchanged.
- R9: `irq` is high exactly when some cause bit and its matching mask bit are both 1.
- R10: The two counters are independent. Each follows only its own enable, reload, count and reload-value bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count-enable pulse shared by both counters |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt: any cause bit with its mask bit set |

## Verification
Register writes, count steps, reloads, one-shot stops and cause updates all take effect at the clock edge on which the strobe or tick is sampled. Read data follows the address within the same cycle, and `irq` follows cause and mask in that cycle. The bench therefore drives every input on the falling edge. It reads registers and samples `irq` on a later falling edge, after the rising edges it intends to count, so a run of N ticks is exactly N rising edges with `tick_en` high. The expected counts in the vector table were derived by hand from the decrement, expiry and reload rules, including the expiry tick at zero.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
   localparam int OFF_CTRL     = 'h00;
   localparam int OFF_RLD_BASE = 'h10;
   localparam int OFF_VAL_BASE = 'h14;
   localparam int OFF_STRIDE   = 8;
   localparam int OFF_CAUSE    = 'h40;
   localparam int OFF_MASK     = 'h44;
   localparam int MAX_TMR      = (OFF_CAUSE - OFF_RLD_BASE) / OFF_STRIDE;

   localparam int CTRL_EN_BIT = 0;
   localparam int CTRL_RL_BIT = 1;
   localparam int CTRL_STRIDE = 2;
endpackage

// File: rtl/dtm_channel.sv
module dtm_channel #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             en,
   input  logic             rl,
   input  logic             rld_we,
   input  logic             val_we,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] rld,
   output logic             expire,
   output logic             stop
);
   logic step;
   logic at_zero;

   assign step    = en & tick;
   assign at_zero = (cnt == '0);
   assign expire  = step & at_zero & ~val_we;
   assign stop    = expire & ~rl;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rld <= '0;
      end else if (rld_we) begin
         rld <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (val_we) begin
         cnt <= wdata;
      end else if (step) begin
         if (at_zero) begin
            cnt <= rl ? rld : '0;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end
endmodule

// File: rtl/dtm_ctrl_reg.sv
module dtm_ctrl_reg #(
   parameter int N_TMR = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [2*N_TMR-1:0]   wdata,
   input  logic [N_TMR-1:0]     stop,
   output logic [2*N_TMR-1:0]   ctrl,
   output logic [N_TMR-1:0]     en,
   output logic [N_TMR-1:0]     rl
);
   import dtm_pkg::*;

   logic [2*N_TMR-1:0] clr_mask;

   for (genvar i = 0; i < N_TMR; i++) begin : g_bits
      assign en[i] = ctrl[CTRL_STRIDE*i + CTRL_EN_BIT];
      assign rl[i] = ctrl[CTRL_STRIDE*i + CTRL_RL_BIT];
      assign clr_mask[CTRL_STRIDE*i + CTRL_EN_BIT] = stop[i];
      assign clr_mask[CTRL_STRIDE*i + CTRL_RL_BIT] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (we) begin
         ctrl <= wdata;
      end else begin
         ctrl <= ctrl & ~clr_mask;
      end
   end
endmodule

// File: rtl/dtm_irq.sv
module dtm_irq #(
   parameter int N_TMR   = 2,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cause_we,
   input  logic             mask_we,
   input  logic [N_TMR-1:0] wdata,
   input  logic [N_TMR-1:0] expire,
   output logic [N_TMR-1:0] cause,
   output logic [N_TMR-1:0] mask,
   output logic             irq
);
   logic [N_TMR-1:0] kept;
   logic             irq_d;

   assign kept  = cause_we ? (cause & wdata) : cause;
   assign irq_d = |(cause & mask);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause <= '0;
         mask  <= '0;
      end else begin
         cause <= kept | expire;
         if (mask_we) begin
            mask <= wdata;
         end
      end
   end

   if (IRQ_REG) begin : g_irq_ff
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            irq <= 1'b0;
         end else begin
            irq <= |((kept | expire) & (mask_we ? wdata : mask));
         end
      end
   end else begin : g_irq_comb
      assign irq = irq_d;
   end
endmodule

// File: rtl/dual_timer.sv
module dual_timer #(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 32,
   parameter int N_TMR   = 2,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   import dtm_pkg::*;

   localparam int CTRL_W = 2 * N_TMR;
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
   localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFF_CAUSE);
   localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFF_MASK);

   if (N_TMR < 1 || N_TMR > MAX_TMR) begin : g_bad_count
      $error("dual_timer: N_TMR out of range");
   end
   if (CNT_W > DATA_W || CTRL_W > DATA_W || CNT_W < 2) begin : g_bad_width
      $error("dual_timer: width parameters inconsistent");
   end
   if ((1 << ADDR_W) <= OFF_MASK) begin : g_bad_addr
      $error("dual_timer: ADDR_W too small for register map");
   end

   function automatic logic [ADDR_W-1:0] rld_addr(input int i);
      return ADDR_W'(OFF_RLD_BASE + OFF_STRIDE * i);
   endfunction

   function automatic logic [ADDR_W-1:0] val_addr(input int i);
      return ADDR_W'(OFF_VAL_BASE + OFF_STRIDE * i);
   endfunction

   logic                              ctrl_we;
   logic                              cause_we;
   logic                              mask_we;
   logic [CTRL_W-1:0]                 ctrl_q;
   logic [N_TMR-1:0]                  en_a;
   logic [N_TMR-1:0]                  rl_a;
   logic [N_TMR-1:0]                  rwe_a;
   logic [N_TMR-1:0]                  vwe_a;
   logic [N_TMR-1:0]                  exp_a;
   logic [N_TMR-1:0]                  stop_a;
   logic [N_TMR-1:0]                  cause_q;
   logic [N_TMR-1:0]                  mask_q;
   logic [N_TMR-1:0][CNT_W-1:0]       cnt_a;
   logic [N_TMR-1:0][CNT_W-1:0]       rld_a;

   assign ctrl_we  = bus_we && (bus_addr == A_CTRL);
   assign cause_we = bus_we && (bus_addr == A_CAUSE);
   assign mask_we  = bus_we && (bus_addr == A_MASK);

   dtm_ctrl_reg #(.N_TMR(N_TMR)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ctrl_we),
      .wdata (bus_wdata[CTRL_W-1:0]),
      .stop  (stop_a),
      .ctrl  (ctrl_q),
      .en    (en_a),
      .rl    (rl_a)
   );

   for (genvar i = 0; i < N_TMR; i++) begin : g_ch
      assign rwe_a[i] = bus_we && (bus_addr == rld_addr(i));
      assign vwe_a[i] = bus_we && (bus_addr == val_addr(i));

      dtm_channel #(.CNT_W(CNT_W)) u_ch (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick   (tick_en),
         .en     (en_a[i]),
         .rl     (rl_a[i]),
         .rld_we (rwe_a[i]),
         .val_we (vwe_a[i]),
         .wdata  (bus_wdata[CNT_W-1:0]),
         .cnt    (cnt_a[i]),
         .rld    (rld_a[i]),
         .expire (exp_a[i]),
         .stop   (stop_a[i])
      );
   end

   dtm_irq #(.N_TMR(N_TMR), .IRQ_REG(IRQ_REG)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .cause_we (cause_we),
      .mask_we  (mask_we),
      .wdata    (bus_wdata[N_TMR-1:0]),
      .expire   (exp_a),
      .cause    (cause_q),
      .mask     (mask_q),
      .irq      (irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_CTRL)  bus_rdata[CTRL_W-1:0] = ctrl_q;
      if (bus_addr == A_CAUSE) bus_rdata[N_TMR-1:0]  = cause_q;
      if (bus_addr == A_MASK)  bus_rdata[N_TMR-1:0]  = mask_q;
      for (int i = 0; i < N_TMR; i++) begin
         if (bus_addr == rld_addr(i)) bus_rdata[CNT_W-1:0] = rld_a[i];
         if (bus_addr == val_addr(i)) bus_rdata[CNT_W-1:0] = cnt_a[i];
      end
   end
endmodule

// File: rtl/dtm_chk.sv
module dtm_chk #(
   parameter int CNT_W = 32,
   parameter int N_TMR = 2
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        tick,
   input logic                        ctrl_we,
   input logic [CNT_W-1:0]            wdata,
   input logic [N_TMR-1:0]            en,
   input logic [N_TMR-1:0]            rl,
   input logic [N_TMR-1:0]            vwe,
   input logic [N_TMR-1:0]            expire,
   input logic [N_TMR-1:0][CNT_W-1:0] cnt,
   input logic [N_TMR-1:0][CNT_W-1:0] rld,
   input logic [N_TMR-1:0]            cause,
   input logic [N_TMR-1:0]            mask,
   input logic                        irq
);
   for (genvar i = 0; i < N_TMR; i++) begin : g_ch
      a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (!(en[i] && tick) && !vwe[i]) |=> $stable(cnt[i]));

      a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
         (en[i] && tick && !vwe[i] && cnt[i] != '0) |=> (cnt[i] == $past(cnt[i]) - 1'b1));

      a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
         (en[i] && tick && !vwe[i] && cnt[i] == '0 && rl[i]) |=> (cnt[i] == $past(rld[i])));

      a_r5_oneshot: assert property (@(posedge clk) disable iff (!rst_n)
         (en[i] && tick && !vwe[i] && cnt[i] == '0 && !rl[i] && !ctrl_we)
            |=> (cnt[i] == '0 && !en[i]));

      a_r6_direct: assert property (@(posedge clk) disable iff (!rst_n)
         vwe[i] |=> (cnt[i] == $past(wdata)));

      a_r8_cause_set: assert property (@(posedge clk) disable iff (!rst_n)
         expire[i] |=> cause[i]);
   end

   a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0 && $past(mask) == '0) |-> !irq);
endmodule

bind dual_timer dtm_chk #(.CNT_W(CNT_W), .N_TMR(N_TMR)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick_en),
   .ctrl_we (ctrl_we),
   .wdata   (bus_wdata[CNT_W-1:0]),
   .en      (en_a),
   .rl      (rl_a),
   .vwe     (vwe_a),
   .expire  (exp_a),
   .cnt     (cnt_a),
   .rld     (rld_a),
   .cause   (cause_q),
   .mask    (mask_q),
   .irq     (irq)
);

// File: tb/dual_timer_tb.sv
module dual_timer_tb;
   localparam logic [7:0] A_CTRL = 8'h00, A_RLD0 = 8'h10, A_VAL0 = 8'h14,
                          A_RLD1 = 8'h18, A_VAL1 = 8'h1C, A_CAUSE = 8'h40, A_MASK = 8'h44;
   localparam int NV = 10;
   // Vector table for counter 0: reload, start count, reload on, ticks, expected count/cause/enable
   localparam logic [31:0] V_RLD [NV] = '{32'd9, 32'd9, 32'd9, 32'd9, 32'hFFFFFFFF,
                                          32'hFFFFFFFF, 32'd3, 32'd3, 32'd3, 32'd3};
   localparam logic [31:0] V_START [NV] = '{32'd5, 32'd5, 32'd5, 32'd5, 32'd0,
                                            32'hFFFFFFFF, 32'd2, 32'd2, 32'd2, 32'd0};
   localparam logic V_RL [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
   localparam int V_N [NV] = '{3, 5, 6, 8, 1, 3, 2, 3, 7, 9};
   localparam logic [31:0] V_CNT [NV] = '{32'd2, 32'd0, 32'd9, 32'd7, 32'hFFFFFFFF,
                                          32'hFFFFFFFC, 32'd0, 32'd0, 32'd0, 32'd3};
   localparam logic V_CAUSE [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
   localparam logic V_EN [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;
   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   dual_timer u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic ticks(input int n);
      if (n > 0) begin
         @(negedge clk);
         tick_en = 1'b1;
         repeat (n) @(negedge clk);
         tick_en = 1'b0;
      end
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_CTRL, v);  check("R1 ctrl", v, 32'h0);
      rd(A_VAL0, v);  check("R1 val0", v, 32'h0);
      rd(A_VAL1, v);  check("R1 val1", v, 32'h0);
      rd(A_RLD0, v);  check("R1 rld0", v, 32'h0);
      rd(A_CAUSE, v); check("R1 cause", v, 32'h0);
      rd(A_MASK, v);  check("R1 mask", v, 32'h0);
      check("R1 irq", {31'b0, irq}, 32'h0);

      // R3 R4 R5 vector walk on counter 0
      for (int k = 0; k < NV; k++) begin
         wr(A_CTRL, 32'h0);
         wr(A_CAUSE, 32'h0);
         wr(A_RLD0, V_RLD[k]);
         wr(A_VAL0, V_START[k]);
         wr(A_CTRL, {30'b0, V_RL[k], 1'b1});
         ticks(V_N[k]);
         rd(A_VAL0, v);  check($sformatf("R3/R4/R5 vec%0d count", k), v, V_CNT[k]);
         rd(A_CAUSE, v); check($sformatf("R8 vec%0d cause", k), v, {31'b0, V_CAUSE[k]});
         rd(A_CTRL, v);  check($sformatf("R5 vec%0d enable", k), v, {30'b0, V_RL[k], V_EN[k]});
      end

      // R2 hold without tick, and with enable clear
      wr(A_CTRL, 32'h3);
      wr(A_VAL0, 32'd50);
      repeat (5) @(negedge clk);
      rd(A_VAL0, v); check("R2 no tick hold", v, 32'd50);
      wr(A_CTRL, 32'h0);
      ticks(4);
      rd(A_VAL0, v); check("R2 disabled hold", v, 32'd50);

      // R6 direct write beats a tick in the same cycle
      wr(A_CTRL, 32'h3);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = A_VAL0; bus_wdata = 32'd100; tick_en = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; tick_en = 1'b0;
      rd(A_VAL0, v); check("R6 write priority", v, 32'd100);

      // R7 R10 independent counters, counter 1 one-shot
      wr(A_CTRL, 32'h0);
      wr(A_CAUSE, 32'h0);
      wr(A_RLD0, 32'd7);
      wr(A_VAL0, 32'd7);
      wr(A_RLD1, 32'hAA);
      rd(A_RLD1, v); check("R7 rld1 readback", v, 32'hAA);
      wr(A_VAL1, 32'd3);
      wr(A_CTRL, 32'h7);
      rd(A_CTRL, v); check("R7 ctrl readback", v, 32'h7);
      ticks(4);
      rd(A_VAL0, v);  check("R10 val0", v, 32'd3);
      rd(A_VAL1, v);  check("R5 val1 stopped", v, 32'd0);
      rd(A_CTRL, v);  check("R5 ctrl bit2 cleared", v, 32'h3);
      rd(A_CAUSE, v); check("R8 cause bit1", v, 32'h2);
      ticks(4);
      rd(A_VAL0, v);  check("R4 val0 reload", v, 32'd7);
      rd(A_VAL1, v);  check("R10 val1 idle", v, 32'd0);
      rd(A_CAUSE, v); check("R8 both causes", v, 32'h3);

      // R8 write-zero-to-clear
      wr(A_CTRL, 32'h0);
      wr(A_CAUSE, 32'h2);
      rd(A_CAUSE, v); check("R8 partial clear", v, 32'h2);

      // R9 interrupt qualification
      check("R9 mask zero", {31'b0, irq}, 32'h0);
      wr(A_MASK, 32'h2);
      rd(A_MASK, v); check("R7 mask readback", v, 32'h2);
      check("R9 masked on", {31'b0, irq}, 32'h1);
      wr(A_MASK, 32'h1);
      check("R9 wrong mask", {31'b0, irq}, 32'h0);
      wr(A_MASK, 32'h3);
      check("R9 full mask", {31'b0, irq}, 32'h1);
      wr(A_CAUSE, 32'h0);
      check("R9 cleared", {31'b0, irq}, 32'h0);

      finish_run();
   end
endmodule